// File: doc/BRIEF.md
# Framed Control Command Serializer

This block sends one control command at a time as a framed serial bit stream, one bit per clock on a 100 MHz line clock. A requester picks one of four commands (start-of-train, stop-of-train, front-end reset, reserved) and asserts a request strobe while the block is ready. The block builds the frame, shifts it out most significant bit first and lowers `ready` until the last bit is on the line. Between frames the line sits low. Every opcode begins with a 1, so the first high bit after idle marks the start of a frame.

A start-of-train frame carries a train number, a bunch pattern number and a one-byte check value. The check value is the XOR of the five payload bytes. The train number comes from an internal counter that starts at zero after reset and advances once for each internally numbered start frame. When the external-number select is high, it is taken from an input instead, and the counter is reloaded to follow on from that number. All other commands are bare 4-bit opcodes. A request that arrives while the block is busy is discarded, and this is reported by a one-cycle flag.

Top module: `cmd_line_tx`

## Requirements
- R1: The 2-bit command select maps 0 to opcode 1100, 1 to 1010, 2 to 1001 and 3 to 1111. The opcode leads every frame, and its leftmost bit goes first.
- R2: A start frame (select 0) is 52 bits long and is sent in this order: opcode, train number bits 31 down to 0, pattern bits 7 down to 0, check byte bits 7 down to 0.
- R3: The check byte equals train[31:24] ^ train[23:16] ^ train[15:8] ^ train[7:0] ^ pattern.
- R4: Selects 1, 2 and 3 produce a frame of exactly 4 opcode bits, with no payload bits after them.
- R5: The first frame bit is on `ser_out` in the cycle after the accepting clock edge. `ser_out` is low in every cycle in which no frame bit is being sent.
- R6: `ready` is low from the cycle after acceptance until the cycle that carries the last frame bit, and it is high in that cycle. A request held during that cycle starts the next frame with no idle gap.
- R7: A request made while `ready` is low is ignored. The current frame continues unchanged, no further frame follows from that request, and `drop` is high for the cycle after it.
- R8: With the external-number select low, the first start frame after reset carries train number 0. Each later internally numbered start frame carries the previous number plus one. Frames for selects 1 to 3 leave the number unchanged.
- R9: With the external-number select high at acceptance, a start frame carries `ext_train_id`. The next internally numbered start frame then carries `ext_train_id + 1`.
- R10: Synchronous reset, including a reset in the middle of a frame, forces `ser_out` low, `ready` high and `drop` low, and returns the train counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock (100 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request strobe |
| req_cmd | input | 2 | Command select: 0 start, 1 stop, 2 reset, 3 reserved |
| ext_id_en | input | 1 | Take the train number from `ext_train_id` for this start frame |
| ext_train_id | input | 32 | Externally supplied train number |
| pattern_id | input | 8 | Bunch pattern number for start frames |
| ser_out | output | 1 | Serial command line, idles low |
| ready | output | 1 | High when a request will be accepted on the next edge |
| drop | output | 1 | One-cycle pulse after a request made while busy |

## Verification
The hardest condition to reach from the ports is the single cycle in which the last bit of a frame is on the line and `ready` is already high. A request held there must start a new frame with no gap, while the same request held one cycle earlier must be dropped. The bench keeps a stop request asserted across two frames and checks that the eight bits come out continuously. A busy-time request is also injected in the middle of a start frame, together with a change to the pattern input, to show that the frame already latched is not disturbed. Sweeps over pattern values, internal and external train numbers, and a reset in the middle of a frame cover the counter and check-byte arithmetic.

// File: rtl/cmd_line_pkg.sv
package cmd_line_pkg;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_STOP  = 2'd1,
    SEL_RESET = 2'd2,
    SEL_RSVD  = 2'd3
  } cmd_sel_e;

  localparam int OPC_W = 4;

  // R1: opcode per command select
  function automatic logic [OPC_W-1:0] opcode_of(input cmd_sel_e sel);
    case (sel)
      SEL_START: opcode_of = 4'b1100;
      SEL_STOP:  opcode_of = 4'b1010;
      SEL_RESET: opcode_of = 4'b1001;
      default:   opcode_of = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cl_checksum.sv
module cl_checksum #(
  parameter int DATA_W = 40,
  parameter int CS_W   = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [CS_W-1:0]   csum
);
  localparam int NSLICE = DATA_W / CS_W;

  logic [CS_W-1:0] acc [NSLICE+1];

  assign acc[0] = '0;

  // R3: fold every byte of the payload with XOR
  for (genvar g = 0; g < NSLICE; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ data[g*CS_W +: CS_W];
  end

  assign csum = acc[NSLICE];
endmodule

// File: rtl/cl_train_ctr.sv
module cl_train_ctr #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            load,
  input  logic [ID_W-1:0] load_val,
  output logic [ID_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val + ID_W'(1);
    else if (inc)  cnt <= cnt + ID_W'(1);
  end

  // R8
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (cnt == $past(cnt) + ID_W'(1)));

  // R9
  ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val) + ID_W'(1)));
endmodule

// File: rtl/cl_serializer.sv
module cl_serializer #(
  parameter int FRAME_W = 52,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               ser_out,
  output logic               ready
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      remaining <= '0;
      ser_out   <= 1'b0;
      ready     <= 1'b1;
    end else if (start) begin
      ser_out   <= frame[FRAME_W-1];
      shreg     <= frame << 1;
      remaining <= len - CNT_W'(1);
      ready     <= (len == CNT_W'(1));
    end else if (remaining != '0) begin
      ser_out   <= shreg[FRAME_W-1];
      shreg     <= shreg << 1;
      remaining <= remaining - CNT_W'(1);
      ready     <= (remaining == CNT_W'(1));
    end else begin
      ser_out   <= 1'b0;
      ready     <= 1'b1;
    end
  end

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> !ser_out);

  // R5
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> ser_out);

  // R6
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && len > CNT_W'(1)) |=> !ready);
endmodule

// File: rtl/cmd_line_tx.sv
module cmd_line_tx
  import cmd_line_pkg::*;
#(
  parameter int ID_W  = 32,
  parameter int PAT_W = 8,
  parameter int CS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic             ext_id_en,
  input  logic [ID_W-1:0]  ext_train_id,
  input  logic [PAT_W-1:0] pattern_id,
  output logic             ser_out,
  output logic             ready,
  output logic             drop
);
  localparam int PAY_W   = ID_W + PAT_W;
  localparam int FRAME_W = OPC_W + PAY_W + CS_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  cmd_sel_e           sel;
  logic               accept, is_start;
  logic [ID_W-1:0]    ctr_val, tid;
  logic [CS_W-1:0]    csum;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  assign sel      = cmd_sel_e'(req_cmd);
  assign accept   = req_valid && ready;
  assign is_start = (sel == SEL_START);
  assign tid      = ext_id_en ? ext_train_id : ctr_val;

  cl_train_ctr #(.ID_W(ID_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .inc      (accept && is_start && !ext_id_en),
    .load     (accept && is_start && ext_id_en),
    .load_val (ext_train_id),
    .cnt      (ctr_val)
  );

  cl_checksum #(.DATA_W(PAY_W), .CS_W(CS_W)) u_cs (
    .data (PAY_W'({tid, pattern_id})),
    .csum (csum)
  );

  always_comb begin
    if (is_start) begin
      frame = {opcode_of(sel), tid, pattern_id, csum};
      len   = CNT_W'(FRAME_W);
    end else begin
      frame = {opcode_of(sel), {(FRAME_W-OPC_W){1'b0}}};
      len   = CNT_W'(OPC_W);
    end
  end

  cl_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .frame   (frame),
    .len     (len),
    .ser_out (ser_out),
    .ready   (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) drop <= 1'b0;
    else     drop <= req_valid && !ready;
  end

  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ready) |=> drop);

  // R7
  no_false_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid) |=> !drop);
endmodule

// File: tb/sim_cmd_line_tx.sv
module sim_cmd_line_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cmd = 2'd0;
  logic        ext_id_en = 1'b0;
  logic [31:0] ext_train_id = '0;
  logic [7:0]  pattern_id = '0;
  logic        ser_out, ready, drop;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model_ctr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmd_line_tx u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .ext_id_en(ext_id_en), .ext_train_id(ext_train_id), .pattern_id(pattern_id),
    .ser_out(ser_out), .ready(ready), .drop(drop)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] opv(input logic [1:0] c);
    case (c)
      2'd0: opv = 4'b1100;   // R1
      2'd1: opv = 4'b1010;
      2'd2: opv = 4'b1001;
      default: opv = 4'b1111;
    endcase
  endfunction

  task automatic send_frame(input logic [1:0] cmd, input bit xen, input logic [31:0] xid,
                            input logic [7:0] pat, input int poke, input string tag);
    logic [51:0] got, exp;
    logic [31:0] id;
    logic [7:0]  cs;
    int len;
    got = '0;
    if (cmd == 2'd0) begin
      len = 52;
      id  = xen ? xid : model_ctr;
      model_ctr = id + 32'd1;
      cs  = id[31:24] ^ id[23:16] ^ id[15:8] ^ id[7:0] ^ pat;  // R3
      exp = {opv(cmd), id, pat, cs};
    end else begin
      len = 4;
      exp = {48'b0, opv(cmd)};
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; ext_id_en = xen; ext_train_id = xid; pattern_id = pat;
    @(negedge clk);
    req_valid = 1'b0;
    pattern_id = ~pat;
    ext_train_id = ~xid;
    for (int i = 0; i < len; i++) begin
      got = {got[50:0], ser_out};
      if (i == 0 && len > 1) chk(!ready, "R6 busy after accept", 64'(ready), 64'd0);
      if (i == len - 1) chk(ready, "R6 ready on last bit", 64'(ready), 64'd1);
      if (poke >= 0 && i == poke + 1) begin
        chk(drop, "R7 drop flag", 64'(drop), 64'd1);
        req_valid = 1'b0;
      end
      if (poke >= 0 && i == poke) begin
        req_valid = 1'b1; req_cmd = 2'd2;
      end
      @(negedge clk);
    end
    chk(got == exp, tag, 64'(got), 64'(exp));
    chk(ser_out == 1'b0, "R5 idle low after frame", 64'(ser_out), 64'd0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b2b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(ser_out == 0, "R10 reset line low", 64'(ser_out), 64'd0);
    chk(ready == 1, "R10 reset ready high", 64'(ready), 64'd1);
    chk(drop == 0, "R10 reset drop low", 64'(drop), 64'd0);

    // R8 first internal start carries 0, then counts; R2 R3 sweep over patterns
    for (int p = 0; p < 16; p++)
      send_frame(2'd0, 1'b0, 32'h0, 8'(p * 17 + 3), -1, "R2 R3 R8 start frame internal id");

    // R1 R4 short frames, R8 counter untouched by them
    send_frame(2'd1, 1'b0, 32'h0, 8'h00, -1, "R1 R4 stop frame");
    send_frame(2'd2, 1'b0, 32'h0, 8'h00, -1, "R1 R4 reset frame");
    send_frame(2'd3, 1'b0, 32'h0, 8'h00, -1, "R1 R4 reserved frame");
    send_frame(2'd0, 1'b0, 32'h0, 8'hA5, -1, "R8 start after short frames");

    // R9 external ids, then internal continues from ext+1
    for (int k = 0; k < 6; k++) begin
      send_frame(2'd0, 1'b1, 32'h1234_5678 * (k + 1) + 32'hFFFF_FFF0, 8'(k * 41), -1, "R9 start frame external id");
      send_frame(2'd0, 1'b0, 32'h0, 8'(k), -1, "R9 internal follows external");
    end
    send_frame(2'd0, 1'b1, 32'hFFFF_FFFF, 8'hFF, -1, "R3 R9 all ones wrap");
    send_frame(2'd0, 1'b0, 32'h0, 8'h00, -1, "R8 wrap to zero");

    // R7 request while busy ignored
    send_frame(2'd0, 1'b0, 32'h0, 8'h3C, 7, "R7 frame unchanged by busy request");
    send_frame(2'd1, 1'b0, 32'h0, 8'h00, 1, "R7 stop unchanged by busy request");

    // R6 back-to-back frames with no gap
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd1;
    @(negedge clk);
    b2b = '0;
    for (int i = 0; i < 8; i++) begin
      b2b = {b2b[6:0], ser_out};
      if (i == 4) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(b2b == 8'b1010_1010, "R6 back-to-back stop frames", 64'(b2b), 64'hAA);
    chk(ser_out == 0, "R6 line low after second frame", 64'(ser_out), 64'd0);

    // R10 reset mid-frame
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd0; ext_id_en = 1'b0; pattern_id = 8'h11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(ser_out == 0, "R10 mid-frame reset line low", 64'(ser_out), 64'd0);
    chk(ready == 1, "R10 mid-frame reset ready", 64'(ready), 64'd1);
    rst = 1'b0;
    model_ctr = '0;
    repeat (2) @(negedge clk);
    chk(ser_out == 0, "R10 idle after reset", 64'(ser_out), 64'd0);
    send_frame(2'd0, 1'b0, 32'h0, 8'h5A, -1, "R10 counter zero after reset");
    send_frame(2'd0, 1'b0, 32'h0, 8'h5B, -1, "R8 count after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule